// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every instruction fetch and data load or store, whether the access is permitted. Privileged software programs up to sixteen address regions through a simple register-write port. Each region has an enable, a lower and an upper bound at 32-byte granularity, a two-bit permission code, an execute-never flag and four memory-attribute bits. The lookup path is purely combinational: in the same cycle as the access it returns permit or deny, whether a region matched, and that region's attributes.

A denied access that is marked valid produces a one-cycle fault pulse on the following clock edge. The pulse is a memory-management fault when that fault class is built in, enabled and urgent enough to preempt the current execution priority. Otherwise it is a hard fault. The block also keeps sticky status flags and, for data accesses only, a captured fault address. Vector-table fetches, debug-originated accesses and the system control address window are never checked. Separate secure and non-secure copies are made by instantiating the block twice, each with its own `NUM_REGIONS`.

The access side has no back-pressure. There is no ready signal, so every cycle with `acc_valid` high is one complete access, decided in that cycle. Outside valid cycles the lookup outputs still follow the inputs, but no fault is raised and no status changes.

Top module: `mpr_checker`

## Requirements
- R1: `NUM_REGIONS` (1 to 16) sets the number of implemented regions. Configuration writes aimed at a region index at or above it have no effect.
- R2: Region r is programmed by two words. The word at `cfg_addr` 8+2r holds the base in bits [31:5], execute-never in bit 4 and the permission code in bits [1:0]. The word at 9+2r holds the limit in bits [31:5], the attributes in bits [4:1] and the enable in bit 0. An address matches when the region is enabled and base <= addr[31:5] <= limit. `acc_hit` then reports the match.
- R3: When several regions match, the highest-numbered one decides the result, and its attributes appear on `acc_attr`. `acc_attr` is zero when the unit is enabled and no region matches.
- R4: Permission code 00 allows privileged read/write. 01 allows read/write at any privilege. 10 allows privileged read-only. 11 allows read-only at any privilege. `acc_kind` is 00 for a fetch, 01 for a read and 10 for a write. A fetch needs read permission.
- R5: A fetch from a matching region with execute-never set is denied.
- R6: The control word at `cfg_addr` 0 holds the unit enable in bit 0, the default-map enable in bit 1, the memory-management fault enable in bit 2 and that fault's priority in bits [11:4]. With the unit disabled, every access is permitted. With it enabled and no region matching, an access is permitted only if it is privileged and the default map is enabled.
- R7: An access is always permitted, whatever the region settings, if `acc_debug` or `acc_vector` is high, or if its address lies within the window `SYS_LO`..`SYS_HI`.
- R8: A valid denied access gives exactly one of `mm_fault` or `hard_fault` on the next cycle. It gives `mm_fault` only when that fault is enabled and its priority value is numerically below `cur_prio`.
- R9: With `HAS_MM_FAULT` = 0, every violation is reported as `hard_fault`.
- R10: A violating fetch sets `flt_iacc` and a violating data access sets `flt_dacc`. Both flags stay set until a write to `cfg_addr` 1 with bit 0 (instruction flag), bit 1 (data flag) or bit 2 (address-valid) set to one. A new fault in the same cycle as a clear wins.
- R11: A violating data access captures its address in `flt_addr` and sets `flt_addr_vld`, unless the address-valid flag is already set. Fetch violations never touch the address.
- R12: No fault is raised and no status changes while `acc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cur_prio | input | 8 | Current execution priority (lower value is more urgent) |
| acc_valid | input | 1 | Access present this cycle |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write |
| acc_addr | input | 32 | Access address |
| acc_priv | input | 1 | Access is privileged |
| acc_debug | input | 1 | Access comes from a debugger |
| acc_vector | input | 1 | Access is a vector-table fetch |
| acc_permit | output | 1 | Access allowed (combinational) |
| acc_hit | output | 1 | An enabled region matched (combinational) |
| acc_attr | output | 4 | Attributes {ordered, merge, cacheable, bufferable} of the deciding region |
| mm_fault | output | 1 | Memory-management fault pulse |
| hard_fault | output | 1 | Hard fault pulse |
| flt_iacc | output | 1 | Sticky instruction-access violation flag |
| flt_dacc | output | 1 | Sticky data-access violation flag |
| flt_addr_vld | output | 1 | Captured fault address is valid |
| flt_addr | output | 32 | Captured data fault address |

## Verification
The properties assume that `acc_kind` never takes the value 11 and that configuration writes happen only between accesses, so that a region never changes while a check for it is still being decided. The stimulus drives each access for exactly one cycle on the falling edge, then drops `acc_valid` before the next edge. All register writes are issued in their own cycles with `acc_valid` low. The window and priority values used keep strictly to the encodings stated in the requirements.

// File: rtl/mpr_pkg.sv
`timescale 1ns/1ps
package mpr_pkg;
  localparam int ADDR_W   = 32;
  localparam int GRAN_W   = 5;
  localparam int PAGE_W   = ADDR_W - GRAN_W;
  localparam int ATTR_W   = 4;
  localparam int CFG_AW   = 6;
  localparam int PRIO_W   = 8;

  localparam logic [CFG_AW-1:0] CTRL_IDX   = 6'd0;
  localparam logic [CFG_AW-1:0] CLEAR_IDX  = 6'd1;
  localparam int                REGION_IDX0 = 8;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10
  } acc_kind_e;

  typedef struct packed {
    logic              en;
    logic [PAGE_W-1:0] base;
    logic [PAGE_W-1:0] limit;
    logic [1:0]        perm;
    logic              xn;
    logic [ATTR_W-1:0] attr;
  } region_t;

  typedef struct packed {
    logic              unit_en;
    logic              dflt_en;
    logic              mm_en;
    logic [PRIO_W-1:0] mm_prio;
  } ctrl_t;
endpackage

// File: rtl/mpr_regfile.sv
`timescale 1ns/1ps
module mpr_regfile
  import mpr_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [31:0]              cfg_wdata,
  output region_t [NUM_REGIONS-1:0] regions,
  output ctrl_t                    ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (cfg_we && cfg_addr == CTRL_IDX) begin
      ctrl.unit_en <= cfg_wdata[0];
      ctrl.dflt_en <= cfg_wdata[1];
      ctrl.mm_en   <= cfg_wdata[2];
      ctrl.mm_prio <= cfg_wdata[4 +: PRIO_W];
    end
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    localparam logic [CFG_AW-1:0] LO_IDX = CFG_AW'(REGION_IDX0 + 2 * r);
    localparam logic [CFG_AW-1:0] HI_IDX = CFG_AW'(REGION_IDX0 + 2 * r + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regions[r] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == LO_IDX) begin
          regions[r].base <= cfg_wdata[31:GRAN_W];
          regions[r].xn   <= cfg_wdata[4];
          regions[r].perm <= cfg_wdata[1:0];
        end else if (cfg_addr == HI_IDX) begin
          regions[r].limit <= cfg_wdata[31:GRAN_W];
          regions[r].attr  <= cfg_wdata[4:1];
          regions[r].en    <= cfg_wdata[0];
        end
      end
    end
  end
endmodule

// File: rtl/mpr_region_match.sv
`timescale 1ns/1ps
module mpr_region_match
  import mpr_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  logic [ADDR_W-1:0]         addr,
  input  region_t [NUM_REGIONS-1:0] regions,
  output logic [NUM_REGIONS-1:0]    hit_vec
);
  logic [PAGE_W-1:0] page;
  assign page = addr[ADDR_W-1:GRAN_W];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
    assign hit_vec[r] = regions[r].en
                      && (page >= regions[r].base)
                      && (page <= regions[r].limit);
  end
endmodule

// File: rtl/mpr_resolve.sv
`timescale 1ns/1ps
module mpr_resolve
  import mpr_pkg::*;
#(
  parameter int                NUM_REGIONS = 8,
  parameter logic [ADDR_W-1:0] SYS_LO      = 32'hE000_0000,
  parameter logic [ADDR_W-1:0] SYS_HI      = 32'hE00F_FFFF
) (
  input  logic [NUM_REGIONS-1:0]    hit_vec,
  input  region_t [NUM_REGIONS-1:0] regions,
  input  ctrl_t                     ctrl,
  input  logic [1:0]                acc_kind,
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic                      acc_priv,
  input  logic                      acc_debug,
  input  logic                      acc_vector,
  output logic                      permit,
  output logic                      hit,
  output logic [ATTR_W-1:0]         attr
);
  region_t sel;
  logic    any_hit;
  logic    bypass;
  logic    priv_ok, write_ok, exec_ok, region_ok;

  // Later (higher-numbered) matches override earlier ones.
  always_comb begin
    sel     = '0;
    any_hit = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit_vec[i]) begin
        sel     = regions[i];
        any_hit = 1'b1;
      end
    end
  end

  assign bypass = acc_debug || acc_vector
               || (acc_addr >= SYS_LO && acc_addr <= SYS_HI);

  assign priv_ok   = acc_priv || sel.perm[0];
  assign write_ok  = !(acc_kind == KIND_WRITE && sel.perm[1]);
  assign exec_ok   = !(acc_kind == KIND_FETCH && sel.xn);
  assign region_ok = priv_ok && write_ok && exec_ok;

  always_comb begin
    if (bypass || !ctrl.unit_en) permit = 1'b1;
    else if (any_hit)            permit = region_ok;
    else                         permit = acc_priv && ctrl.dflt_en;
  end

  assign hit  = ctrl.unit_en && any_hit;
  assign attr = hit ? sel.attr : '0;
endmodule

// File: rtl/mpr_fault_log.sv
`timescale 1ns/1ps
module mpr_fault_log
  import mpr_pkg::*;
#(
  parameter bit HAS_MM_FAULT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              violation,
  input  logic              is_fetch,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              mm_en,
  input  logic [PRIO_W-1:0] mm_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              clr_we,
  input  logic [2:0]        clr_mask,
  output logic              mm_fault,
  output logic              hard_fault,
  output logic              flt_iacc,
  output logic              flt_dacc,
  output logic              flt_addr_vld,
  output logic [ADDR_W-1:0] flt_addr
);
  logic take_mm;

  if (HAS_MM_FAULT) begin : g_mm
    assign take_mm = mm_en && (mm_prio < cur_prio);
  end else begin : g_no_mm
    logic unused_ok;
    assign unused_ok = mm_en ^ (^mm_prio) ^ (^cur_prio);
    assign take_mm   = 1'b0;
  end

  logic iacc_keep, dacc_keep, vld_keep, data_viol;
  assign iacc_keep = flt_iacc     && !(clr_we && clr_mask[0]);
  assign dacc_keep = flt_dacc     && !(clr_we && clr_mask[1]);
  assign vld_keep  = flt_addr_vld && !(clr_we && clr_mask[2]);
  assign data_viol = violation && !is_fetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm_fault     <= 1'b0;
      hard_fault   <= 1'b0;
      flt_iacc     <= 1'b0;
      flt_dacc     <= 1'b0;
      flt_addr_vld <= 1'b0;
      flt_addr     <= '0;
    end else begin
      mm_fault     <= violation && take_mm;
      hard_fault   <= violation && !take_mm;
      flt_iacc     <= iacc_keep || (violation && is_fetch);
      flt_dacc     <= dacc_keep || data_viol;
      flt_addr_vld <= vld_keep || data_viol;
      if (data_viol && !vld_keep) flt_addr <= acc_addr;
    end
  end
endmodule

// File: rtl/mpr_checker.sv
`timescale 1ns/1ps
module mpr_checker
  import mpr_pkg::*;
#(
  parameter int                NUM_REGIONS  = 8,
  parameter bit                HAS_MM_FAULT = 1'b1,
  parameter logic [ADDR_W-1:0] SYS_LO       = 32'hE000_0000,
  parameter logic [ADDR_W-1:0] SYS_HI       = 32'hE00F_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [5:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic [7:0]  cur_prio,
  input  logic        acc_valid,
  input  logic [1:0]  acc_kind,
  input  logic [31:0] acc_addr,
  input  logic        acc_priv,
  input  logic        acc_debug,
  input  logic        acc_vector,
  output logic        acc_permit,
  output logic        acc_hit,
  output logic [3:0]  acc_attr,
  output logic        mm_fault,
  output logic        hard_fault,
  output logic        flt_iacc,
  output logic        flt_dacc,
  output logic        flt_addr_vld,
  output logic [31:0] flt_addr
);
  region_t [NUM_REGIONS-1:0] regions;
  ctrl_t                     ctrl;
  logic [NUM_REGIONS-1:0]    hit_vec;
  logic                      violation;
  logic                      clr_we;

  mpr_regfile #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .regions   (regions),
    .ctrl      (ctrl)
  );

  mpr_region_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
    .addr    (acc_addr),
    .regions (regions),
    .hit_vec (hit_vec)
  );

  mpr_resolve #(
    .NUM_REGIONS (NUM_REGIONS),
    .SYS_LO      (SYS_LO),
    .SYS_HI      (SYS_HI)
  ) u_resolve (
    .hit_vec    (hit_vec),
    .regions    (regions),
    .ctrl       (ctrl),
    .acc_kind   (acc_kind),
    .acc_addr   (acc_addr),
    .acc_priv   (acc_priv),
    .acc_debug  (acc_debug),
    .acc_vector (acc_vector),
    .permit     (acc_permit),
    .hit        (acc_hit),
    .attr       (acc_attr)
  );

  assign violation = acc_valid && !acc_permit;
  assign clr_we    = cfg_we && cfg_addr == CLEAR_IDX;

  mpr_fault_log #(.HAS_MM_FAULT(HAS_MM_FAULT)) u_log (
    .clk          (clk),
    .rst_n        (rst_n),
    .violation    (violation),
    .is_fetch     (acc_kind == KIND_FETCH),
    .acc_addr     (acc_addr),
    .mm_en        (ctrl.mm_en),
    .mm_prio      (ctrl.mm_prio),
    .cur_prio     (cur_prio),
    .clr_we       (clr_we),
    .clr_mask     (cfg_wdata[2:0]),
    .mm_fault     (mm_fault),
    .hard_fault   (hard_fault),
    .flt_iacc     (flt_iacc),
    .flt_dacc     (flt_dacc),
    .flt_addr_vld (flt_addr_vld),
    .flt_addr     (flt_addr)
  );
endmodule

// File: rtl/mpr_checker_sva.sv
`timescale 1ns/1ps
module mpr_checker_sva #(
  parameter bit          HAS_MM_FAULT = 1'b1,
  parameter logic [31:0] SYS_LO       = 32'hE000_0000,
  parameter logic [31:0] SYS_HI       = 32'hE00F_FFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [5:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic        acc_valid,
  input logic [1:0]  acc_kind,
  input logic [31:0] acc_addr,
  input logic        acc_debug,
  input logic        acc_vector,
  input logic        acc_permit,
  input logic        mm_fault,
  input logic        hard_fault,
  input logic        flt_iacc,
  input logic        flt_addr_vld,
  input logic [31:0] flt_addr
);
  // R7
  bypass_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_debug || acc_vector || (acc_addr >= SYS_LO && acc_addr <= SYS_HI))
      |-> acc_permit);

  // R8
  fault_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_permit) |=> (mm_fault || hard_fault));

  // R8
  fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mm_fault && hard_fault));

  // R9
  no_mm_variant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_MM_FAULT |-> !mm_fault);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid || acc_permit) |=> !(mm_fault || hard_fault));

  // R11
  addr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_addr_vld && !(cfg_we && cfg_addr == 6'd1 && cfg_wdata[2])) |=> $stable(flt_addr));

  // R11
  data_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_permit && acc_kind != 2'b00) |=> flt_addr_vld);

  // R10
  fetch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_permit && acc_kind == 2'b00) |=> flt_iacc);
endmodule

bind mpr_checker mpr_checker_sva #(
  .HAS_MM_FAULT (HAS_MM_FAULT),
  .SYS_LO       (SYS_LO),
  .SYS_HI       (SYS_HI)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_addr     (cfg_addr),
  .cfg_wdata    (cfg_wdata),
  .acc_valid    (acc_valid),
  .acc_kind     (acc_kind),
  .acc_addr     (acc_addr),
  .acc_debug    (acc_debug),
  .acc_vector   (acc_vector),
  .acc_permit   (acc_permit),
  .mm_fault     (mm_fault),
  .hard_fault   (hard_fault),
  .flt_iacc     (flt_iacc),
  .flt_addr_vld (flt_addr_vld),
  .flt_addr     (flt_addr)
);

// File: tb/mpr_checker_test.sv
`timescale 1ns/1ps
module mpr_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  cur_prio = 8'hFF;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = 2'b01;
  logic [31:0] acc_addr = '0;
  logic        acc_priv = 1'b0;
  logic        acc_debug = 1'b0;
  logic        acc_vector = 1'b0;

  logic        permit, hit, mmf, hf, fi, fd, fv;
  logic [3:0]  attr;
  logic [31:0] fa;
  logic        n_permit, n_hit, n_mmf, n_hf, n_fi, n_fd, n_fv;
  logic [3:0]  n_attr;
  logic [31:0] n_fa;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] FETCH = 2'b00, READ = 2'b01, WRITE = 2'b10;

  always #2.5 clk = ~clk;

  mpr_checker #(.NUM_REGIONS(8), .HAS_MM_FAULT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cur_prio(cur_prio), .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .acc_priv(acc_priv), .acc_debug(acc_debug), .acc_vector(acc_vector),
    .acc_permit(permit), .acc_hit(hit), .acc_attr(attr), .mm_fault(mmf), .hard_fault(hf),
    .flt_iacc(fi), .flt_dacc(fd), .flt_addr_vld(fv), .flt_addr(fa));

  mpr_checker #(.NUM_REGIONS(4), .HAS_MM_FAULT(1'b0)) uut_nomm (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cur_prio(cur_prio), .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .acc_priv(acc_priv), .acc_debug(acc_debug), .acc_vector(acc_vector),
    .acc_permit(n_permit), .acc_hit(n_hit), .acc_attr(n_attr), .mm_fault(n_mmf), .hard_fault(n_hf),
    .flt_iacc(n_fi), .flt_dacc(n_fd), .flt_addr_vld(n_fv), .flt_addr(n_fa));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  // One-cycle access; checks the lookup in that cycle and the fault one edge later.
  task automatic access(input logic [1:0] kind, input logic [31:0] addr, input logic priv,
                        input logic dbg, input logic vec, input logic exp_permit,
                        input logic exp_hit, input logic [3:0] exp_attr,
                        input logic exp_mm, input logic exp_hf, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = kind; acc_addr = addr;
    acc_priv = priv; acc_debug = dbg; acc_vector = vec;
    #1;
    check({req, " permit"}, 32'(permit), 32'(exp_permit));
    check({req, " hit"},    32'(hit),    32'(exp_hit));
    check({req, " attr"},   32'(attr),   32'(exp_attr));
    @(posedge clk);
    #1;
    check({req, " mm_fault"},   32'(mmf), 32'(exp_mm));
    check({req, " hard_fault"}, 32'(hf),  32'(exp_hf));
    // R9: the variant without the dedicated fault reports every violation as hard
    check("R9 variant hard_fault", 32'(n_hf), 32'(exp_mm | exp_hf));
    check("R9 variant mm_fault",   32'(n_mmf), 32'd0);
    acc_valid = 1'b0; acc_debug = 1'b0; acc_vector = 1'b0;
  endtask

  task automatic chk_status(input logic i, input logic d, input logic v,
                            input logic [31:0] a, input string req);
    check({req, " iacc"},  32'(fi), 32'(i));
    check({req, " dacc"},  32'(fd), 32'(d));
    check({req, " vld"},   32'(fv), 32'(v));
    check({req, " addr"},  fa, a);
  endtask

  task automatic t_reset;
    #1;
    check("R6 reset permit", 32'(permit), 32'd1);
    check("R8 reset faults", 32'({mmf, hf}), 32'd0);
    chk_status(1'b0, 1'b0, 1'b0, 32'h0, "R10 reset");
  endtask

  task automatic t_disabled;
    access(WRITE, 32'h3000_0010, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, "R6 disabled");
  endtask

  task automatic t_configure;
    cfg_write(6'd8,  32'h2000_0001); cfg_write(6'd9,  32'h2000_0FEB);
    cfg_write(6'd10, 32'h2000_0813); cfg_write(6'd11, 32'h2000_08F5);
    cfg_write(6'd12, 32'h3000_0000); cfg_write(6'd13, 32'h3000_0FE7);
    cfg_write(6'd14, 32'h3000_1002); cfg_write(6'd15, 32'h3000_1FE1);
    cfg_write(6'd18, 32'h5000_0001); cfg_write(6'd19, 32'h5000_0FE1);
    cfg_write(6'd0,  32'h0000_0027);
  endtask

  task automatic t_match;
    access(READ,  32'h2000_0100, 0, 0, 0, 1, 1, 4'h5, 0, 0, "R2 inside");
    access(WRITE, 32'h2000_0FFF, 0, 0, 0, 1, 1, 4'h5, 0, 0, "R2 top byte");
    access(READ,  32'h2000_1000, 0, 0, 0, 0, 0, 4'h0, 1, 0, "R2 past limit");
    access(READ,  32'h1FFF_FFFF, 0, 0, 0, 0, 0, 4'h0, 1, 0, "R2 below base");
  endtask

  task automatic t_overlap;
    access(WRITE, 32'h2000_0840, 0, 0, 0, 0, 1, 4'hA, 1, 0, "R3 upper region wins");
    access(READ,  32'h2000_08FF, 0, 0, 0, 1, 1, 4'hA, 0, 0, "R3 upper edge");
    access(WRITE, 32'h2000_0900, 0, 0, 0, 1, 1, 4'h5, 0, 0, "R3 back to lower");
    access(READ,  32'h2000_07FF, 0, 0, 0, 1, 1, 4'h5, 0, 0, "R3 below overlap");
  endtask

  task automatic t_perm;
    access(READ,  32'h3000_0010, 0, 0, 0, 0, 1, 4'h3, 1, 0, "R4 priv-rw unpriv read");
    access(WRITE, 32'h3000_0010, 1, 0, 0, 1, 1, 4'h3, 0, 0, "R4 priv-rw priv write");
    access(WRITE, 32'h3000_1010, 1, 0, 0, 0, 1, 4'h0, 1, 0, "R4 priv-ro priv write");
    access(READ,  32'h3000_1010, 1, 0, 0, 1, 1, 4'h0, 0, 0, "R4 priv-ro priv read");
    access(READ,  32'h3000_1010, 0, 0, 0, 0, 1, 4'h0, 1, 0, "R4 priv-ro unpriv read");
    access(READ,  32'h2000_0840, 0, 0, 0, 1, 1, 4'hA, 0, 0, "R4 ro-any unpriv read");
  endtask

  task automatic t_xn;
    access(FETCH, 32'h2000_0840, 1, 0, 0, 0, 1, 4'hA, 1, 0, "R5 execute-never");
    access(FETCH, 32'h2000_0100, 0, 0, 0, 1, 1, 4'h5, 0, 0, "R5 executable");
  endtask

  task automatic t_default;
    access(READ, 32'h4000_0000, 1, 0, 0, 1, 0, 4'h0, 0, 0, "R6 default priv");
    access(READ, 32'h4000_0000, 0, 0, 0, 0, 0, 4'h0, 1, 0, "R6 default unpriv");
    cfg_write(6'd0, 32'h0000_0025);
    access(READ, 32'h4000_0000, 1, 0, 0, 0, 0, 4'h0, 1, 0, "R6 no default map");
    cfg_write(6'd0, 32'h0000_0027);
  endtask

  task automatic t_bypass;
    access(WRITE, 32'h3000_1010, 0, 1, 0, 1, 1, 4'h0, 0, 0, "R7 debug");
    access(FETCH, 32'h4000_0000, 0, 0, 1, 1, 0, 4'h0, 0, 0, "R7 vector");
    access(WRITE, 32'hE000_ED00, 0, 0, 0, 1, 0, 4'h0, 0, 0, "R7 system window");
    access(READ,  32'hE010_0000, 0, 0, 0, 0, 0, 4'h0, 1, 0, "R7 past window");
  endtask

  task automatic t_escalate;
    cur_prio = 8'h02;
    access(READ, 32'h4000_0000, 0, 0, 0, 0, 0, 4'h0, 0, 1, "R8 equal priority");
    cur_prio = 8'h03;
    access(READ, 32'h4000_0000, 0, 0, 0, 0, 0, 4'h0, 1, 0, "R8 lower priority");
    cur_prio = 8'hFF;
    cfg_write(6'd0, 32'h0000_0023);
    access(READ, 32'h4000_0000, 0, 0, 0, 0, 0, 4'h0, 0, 1, "R8 fault disabled");
    cfg_write(6'd0, 32'h0000_0027);
  endtask

  task automatic t_count;
    @(negedge clk);
    acc_valid = 1'b0; acc_kind = READ; acc_addr = 32'h5000_0100; acc_priv = 1'b0;
    #1;
    check("R1 region 5 present", 32'(permit), 32'd1);
    check("R1 region 5 absent in 4-region copy", 32'(n_permit), 32'd0);
    @(posedge clk);
    #1;
    check("R12 no fault when idle", 32'({mmf, hf, n_mmf, n_hf}), 32'd0);
  endtask

  task automatic t_log;
    cfg_write(6'd1, 32'h7);
    chk_status(0, 0, 0, fa, "R10 cleared");
    access(FETCH, 32'h2000_0840, 1, 0, 0, 0, 1, 4'hA, 1, 0, "R11 fetch fault");
    chk_status(1, 0, 0, fa, "R11 fetch keeps address");
    access(WRITE, 32'h2000_0840, 0, 0, 0, 0, 1, 4'hA, 1, 0, "R11 first data fault");
    chk_status(1, 1, 1, 32'h2000_0840, "R11 captured");
    access(READ, 32'h3000_0010, 0, 0, 0, 0, 1, 4'h3, 1, 0, "R11 second data fault");
    chk_status(1, 1, 1, 32'h2000_0840, "R11 not overwritten");
    cfg_write(6'd1, 32'h1);
    chk_status(0, 1, 1, 32'h2000_0840, "R10 clear instruction only");
    cfg_write(6'd1, 32'h6);
    chk_status(0, 0, 0, 32'h2000_0840, "R10 clear rest");
    access(READ, 32'h3000_0020, 0, 0, 0, 0, 1, 4'h3, 1, 0, "R11 new capture");
    chk_status(0, 1, 1, 32'h3000_0020, "R11 recaptured");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_configure();
    t_match();
    t_overlap();
    t_perm();
    t_xn();
    t_default();
    t_bypass();
    t_escalate();
    t_count();
    t_log();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule